// File: doc/BRIEF.md
# Burst Memory Port Sequencer

This block sits in front of a single-data-rate memory that has one shared data bus but offers the user separate write and read ports. Each port keeps its own address pointer. A one-cycle address strobe loads the pointer, and the pointer then steps by one for every word moved. User logic raises `ready` to ask for a transfer and holds `burst` with it to keep words flowing on back-to-back cycles. The sequencer turns these requests into abstract memory commands: open a row, access a column (write or read), close the row, and refresh. It paces write words with a done strobe, so a show-ahead FIFO can be popped directly by that strobe.

On the read side, the done strobe only marks that a word was requested. The word comes back, flagged by a valid strobe, a fixed five cycles later. A burst never runs past the last column of a row: the sequencer closes the row and, if the same port still asks for data, opens the next row and goes on. An internal timer raises periodic refresh requests. These are served only while no row is open and take priority over new accesses. When both ports are waiting, the sequencer finishes one transfer before it serves the other, and it alternates between them.

Top module: `bmp_sequencer`

## Requirements
- R1: A one-cycle `*_addr_en` loads that port's pointer from `*_addr`. Every done strobe of the port then advances the pointer by one. A later transfer started without a new load continues at the next address.
- R2: No done strobe and no memory command other than refresh is produced while neither `ready` is high. A request made with `burst` low moves exactly one word.
- R3: When the sequencer is idle and no refresh is pending, a `ready` first seen high in cycle t gives the first done strobe in cycle t+4.
- R4: During a write transfer, `wr_done` is high once per word on consecutive cycles while `wr_ready` and `wr_burst` stay high. The word present on `wr_data` in each `wr_done` cycle is the one stored at the current pointer. A done cycle with `burst` low is the last one of the transfer.
- R5: Each `rd_done` requests the word at the read pointer. `rd_valid` is high exactly five cycles after each `rd_done`, with that word on `rd_data`.
- R6: A word at column all-ones (the low `COL_W` address bits) ends the row. The close command follows in the next cycle. If the port still requests with `burst`, the next row is opened and the transfer continues at column 0 without a new address load.
- R7: `wr_done` and `rd_done` are never high in the same cycle. When both ports request, one transfer completes before the other starts. The choice alternates, and writes win the first contest after reset.
- R8: A refresh request arises every `REFRESH_PERIOD` cycles. It is issued only while no row is open, and a pending refresh is issued before any new row open.
- R9: Command codes on `mem_cmd`: 0 none, 1 open row `mem_row`, 2 write `mem_wdata` at column `mem_col`, 3 read column `mem_col` (the memory answers on `mem_rdata` in the same cycle), 4 close, 5 refresh. After reset, `mem_cmd` is 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr_en | input | 1 | Load write pointer |
| wr_addr | input | ADDR_W | Write start address |
| wr_ready | input | 1 | Write data available |
| wr_burst | input | 1 | More than one write word available |
| wr_data | input | DATA_W | Write word, consumed when wr_done is high |
| wr_done | output | 1 | Write word taken this cycle |
| rd_addr_en | input | 1 | Load read pointer |
| rd_addr | input | ADDR_W | Read start address |
| rd_ready | input | 1 | Space for read data |
| rd_burst | input | 1 | Space for more than one read word |
| rd_done | output | 1 | Read word requested this cycle |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_data | output | DATA_W | Read word |
| mem_cmd | output | 3 | Memory command code |
| mem_row | output | ADDR_W-COL_W | Row for open |
| mem_col | output | COL_W | Column for access |
| mem_wdata | output | DATA_W | Write word to memory |
| mem_rdata | input | DATA_W | Read word from memory |

## Verification
The bench builds the block with a 10-bit address and a 3-bit column, so each row holds eight words. This puts row ends within reach of short bursts, and both a write and a read are made to cross one. The refresh period is set to 500 cycles. Early tests therefore finish before the first refresh, so the four-cycle start latency can be measured exactly, and a later idle window of 1000 cycles must hold exactly two refreshes. A behavioural memory model stores words by opened row and column, so the written data and the row changes are judged from the memory side.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
   typedef enum logic [2:0] {
      CMD_NOP     = 3'd0,
      CMD_OPEN    = 3'd1,
      CMD_WRITE   = 3'd2,
      CMD_READ    = 3'd3,
      CMD_CLOSE   = 3'd4,
      CMD_REFRESH = 3'd5
   } mem_cmd_e;

   typedef enum logic [2:0] {
      S_IDLE, S_REFRESH, S_OPEN, S_XFER, S_CLOSE
   } seq_state_e;

   // read data trails its request by this many cycles
   localparam int unsigned RD_LAT = 5;
endpackage

// File: rtl/bmp_addr_port.sv
module bmp_addr_port #(
   parameter int unsigned ADDR_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load)   addr_q <= load_addr;
      else if (step)   addr_q <= addr_q + 1'b1;
   end

   assign addr = addr_q;

   assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr_q == $past(addr_q) + 1'b1));
   assert_addr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_q == $past(load_addr)));
endmodule

// File: rtl/bmp_refresh_timer.sv
module bmp_refresh_timer #(
   parameter int unsigned PERIOD = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   output logic pending
);
   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   logic [CW-1:0] cnt_q;
   logic          pend_q;
   logic          tick;

   assign tick = (cnt_q == CW'(PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
         if (tick)       pend_q <= 1'b1;
         else if (grant) pend_q <= 1'b0;
      end
   end

   assign pending = pend_q;

   assert_pending_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !grant) |=> pend_q);
endmodule

// File: rtl/bmp_rd_pipe.sv
module bmp_rd_pipe #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LAT    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic [LAT-1:0]    vld_q;
   logic [DATA_W-1:0] dat_q [LAT];

   if (LAT < 1) begin : g_bad_lat
      $error("bmp_rd_pipe: LAT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int i = LAT - 1; i > 0; i--) vld_q[i] <= vld_q[i-1];
         vld_q[0] <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = LAT - 1; i > 0; i--) dat_q[i] <= dat_q[i-1];
      dat_q[0] <= in_data;
   end

   assign out_valid = vld_q[LAT-1];
   assign out_data  = dat_q[LAT-1];
endmodule

// File: rtl/bmp_sequencer.sv
module bmp_sequencer
   import bmp_pkg::*;
#(
   parameter int unsigned ADDR_W         = 26,
   parameter int unsigned COL_W          = 9,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned OPEN_LAT       = 4,
   parameter int unsigned RFSH_CYC       = 4,
   parameter int unsigned REFRESH_PERIOD = 1560
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_addr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic                    wr_ready,
   input  logic                    wr_burst,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    wr_done,
   input  logic                    rd_addr_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic                    rd_ready,
   input  logic                    rd_burst,
   output logic                    rd_done,
   output logic                    rd_valid,
   output logic [DATA_W-1:0]       rd_data,
   output logic [2:0]              mem_cmd,
   output logic [ADDR_W-COL_W-1:0] mem_row,
   output logic [COL_W-1:0]        mem_col,
   output logic [DATA_W-1:0]       mem_wdata,
   input  logic [DATA_W-1:0]       mem_rdata
);
   localparam int unsigned CNT_MAX = (OPEN_LAT > RFSH_CYC) ? OPEN_LAT : RFSH_CYC;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] OPEN_LOAD = CNT_W'(OPEN_LAT - 2);
   localparam logic [CNT_W-1:0] RFSH_LOAD = CNT_W'(RFSH_CYC - 1);

   if (OPEN_LAT < 2 || RFSH_CYC < 1 || COL_W < 1 || COL_W >= ADDR_W
       || REFRESH_PERIOD < 2) begin : g_bad_params
      $error("bmp_sequencer: parameter out of range");
   end

   seq_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              dir_q, dir_d;       // 0 write, 1 read
   logic              reopen_q, reopen_d;
   logic [ADDR_W-1:0] wr_ptr, rd_ptr, sel_ptr;
   logic              sel_ready, sel_burst, col_last;
   logic              rfsh_pend, rfsh_grant;
   mem_cmd_e          cmd;

   bmp_addr_port #(.ADDR_W(ADDR_W)) u_wr_port (
      .clk(clk), .rst_n(rst_n), .load(wr_addr_en), .load_addr(wr_addr),
      .step(wr_done), .addr(wr_ptr));

   bmp_addr_port #(.ADDR_W(ADDR_W)) u_rd_port (
      .clk(clk), .rst_n(rst_n), .load(rd_addr_en), .load_addr(rd_addr),
      .step(rd_done), .addr(rd_ptr));

   bmp_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_rfsh (
      .clk(clk), .rst_n(rst_n), .grant(rfsh_grant), .pending(rfsh_pend));

   bmp_rd_pipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_rd_pipe (
      .clk(clk), .rst_n(rst_n), .in_valid(rd_done), .in_data(mem_rdata),
      .out_valid(rd_valid), .out_data(rd_data));

   assign sel_ptr   = dir_q ? rd_ptr   : wr_ptr;
   assign sel_ready = dir_q ? rd_ready : wr_ready;
   assign sel_burst = dir_q ? rd_burst : wr_burst;
   assign col_last  = &sel_ptr[COL_W-1:0];
   assign rfsh_grant = (state_q == S_IDLE) && rfsh_pend;

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      dir_d    = dir_q;
      reopen_d = reopen_q;
      unique case (state_q)
         S_IDLE: begin
            if (rfsh_pend) begin
               state_d = S_REFRESH;
               cnt_d   = RFSH_LOAD;
            end else if (wr_ready || rd_ready) begin
               dir_d   = (wr_ready && rd_ready) ? !dir_q : rd_ready;
               state_d = S_OPEN;
               cnt_d   = OPEN_LOAD;
            end
         end
         S_REFRESH, S_OPEN: begin
            if (cnt_q == '0) state_d = (state_q == S_OPEN) ? S_XFER : S_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         S_XFER: begin
            if (!(sel_ready && sel_burst) || col_last) begin
               state_d  = S_CLOSE;
               reopen_d = col_last && sel_ready && sel_burst;
            end
         end
         S_CLOSE: begin
            if (reopen_q && !rfsh_pend) begin
               state_d = S_OPEN;
               cnt_d   = OPEN_LOAD;
            end else begin
               state_d = S_IDLE;
            end
            reopen_d = 1'b0;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         cnt_q    <= '0;
         dir_q    <= 1'b1;
         reopen_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         cnt_q    <= cnt_d;
         dir_q    <= dir_d;
         reopen_q <= reopen_d;
      end
   end

   always_comb begin
      cmd = CMD_NOP;
      unique case (state_q)
         S_OPEN:    if (cnt_q == OPEN_LOAD) cmd = CMD_OPEN;
         S_XFER:    cmd = dir_q ? CMD_READ : CMD_WRITE;
         S_CLOSE:   cmd = CMD_CLOSE;
         S_REFRESH: if (cnt_q == RFSH_LOAD) cmd = CMD_REFRESH;
         default:   cmd = CMD_NOP;
      endcase
   end

   assign mem_cmd   = cmd;
   assign wr_done   = (state_q == S_XFER) && !dir_q;
   assign rd_done   = (state_q == S_XFER) && dir_q;
   assign mem_row   = sel_ptr[ADDR_W-1:COL_W];
   assign mem_col   = sel_ptr[COL_W-1:0];
   assign mem_wdata = wr_data;

   assert_rd_valid_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == $past(rd_done, RD_LAT));
   assert_row_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_done || rd_done) && $past(wr_done || rd_done)) |-> $stable(mem_row));
   assert_close_at_row_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_done || rd_done) && (&mem_col)) |=> (mem_cmd == 3'(CMD_CLOSE)));
   assert_last_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && !wr_burst) |=> !wr_done);
   assert_refresh_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && rfsh_pend) |=> (mem_cmd == 3'(CMD_REFRESH)));
endmodule

// File: tb/bmp_sequencer_test.sv
`timescale 1ns/1ps
module bmp_sequencer_test;
   localparam int AW = 10, CW = 3, DW = 32, RW = AW - CW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_addr_en = 0, wr_ready = 0, wr_burst = 0;
   logic rd_addr_en = 0, rd_ready = 0, rd_burst = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic wr_done, rd_done, rd_valid;
   logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
   logic [2:0] mem_cmd;
   logic [RW-1:0] mem_row;
   logic [CW-1:0] mem_col;

   int checks = 0, errors = 0, cyc = 0;
   int wdone_cnt = 0, both_cnt = 0, switches = 0, open_cnt = 0, close_cnt = 0;
   int rfsh_cnt = 0, rfsh_open_err = 0, lag_err = 0, rdi = 0, rvi = 0;
   int rdc [512];
   logic [DW-1:0] rx [512];
   logic [DW-1:0] gold [1024];
   logic [DW-1:0] mem [1024];
   logic [RW-1:0] open_row = '0;
   logic is_open = 0, last_s = 0, seen_s = 0;
   int wa = 0, ra = 0;

   always #2.5 clk = ~clk;

   bmp_sequencer #(.ADDR_W(AW), .COL_W(CW), .DATA_W(DW), .OPEN_LAT(4),
                   .RFSH_CYC(3), .REFRESH_PERIOD(500)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_addr_en(wr_addr_en), .wr_addr(wr_addr), .wr_ready(wr_ready),
      .wr_burst(wr_burst), .wr_data(wr_data), .wr_done(wr_done),
      .rd_addr_en(rd_addr_en), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rd_burst(rd_burst), .rd_done(rd_done), .rd_valid(rd_valid),
      .rd_data(rd_data), .mem_cmd(mem_cmd), .mem_row(mem_row),
      .mem_col(mem_col), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   // behavioural memory (R9 command codes)
   assign mem_rdata = mem[{open_row, mem_col}];
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_cmd == 3'd1) begin open_row <= mem_row; is_open <= 1'b1; end
      if (mem_cmd == 3'd4) is_open <= 1'b0;
      if (mem_cmd == 3'd2) mem[{open_row, mem_col}] <= mem_wdata;
   end

   always @(negedge clk) if (rst_n) begin
      if (wr_done) wdone_cnt++;
      if (wr_done && rd_done) both_cnt++;
      if (wr_done || rd_done) begin
         if (seen_s && (last_s != rd_done)) switches++;
         last_s = rd_done; seen_s = 1'b1;
      end
      if (rd_done) begin rdc[rdi] = cyc; rdi++; end
      if (rd_valid) begin
         if (cyc - rdc[rvi] != 5) lag_err++;
         rx[rvi] = rd_data; rvi++;
      end
      if (mem_cmd == 3'd1) open_cnt++;
      if (mem_cmd == 3'd4) close_cnt++;
      if (mem_cmd == 3'd5) begin rfsh_cnt++; if (is_open) rfsh_open_err++; end
   end

   task automatic chk(string req, bit ok, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) if (cyc > 100000) begin
      chk("watchdog", 1'b0, cyc, 100000);
      summary();
   end

   task automatic load_wr(int a);
      @(negedge clk); wr_addr_en = 1; wr_addr = AW'(a); wa = a;
      @(negedge clk); wr_addr_en = 0;
   endtask

   task automatic load_rd(int a);
      @(negedge clk); rd_addr_en = 1; rd_addr = AW'(a); ra = a;
      @(negedge clk); rd_addr_en = 0;
   endtask

   task automatic do_write(int n, int base, output int lat);
      int k = 0, t0 = -1, first = -1;
      while (k < n) begin
         @(negedge clk);
         wr_data = DW'(base + k); wr_burst = (n - k > 1); wr_ready = 1;
         if (t0 < 0) t0 = cyc;
         if (wr_done) begin
            gold[wa] = DW'(base + k); wa++; k++;
            if (first < 0) first = cyc;
         end
      end
      @(negedge clk); wr_ready = 0; wr_burst = 0;
      lat = first - t0;
   endtask

   task automatic do_read(int n, output int start_idx);
      int k = 0;
      start_idx = rdi;
      while (k < n) begin
         @(negedge clk);
         rd_burst = (n - k > 1); rd_ready = 1;
         if (rd_done) k++;
      end
      @(negedge clk); rd_ready = 0; rd_burst = 0;
      repeat (8) @(negedge clk);
   endtask

   task automatic check_mem(string req, int a, int n);
      repeat (3) @(negedge clk);
      for (int i = 0; i < n; i++)
         chk(req, mem[a+i] === gold[a+i], int'(mem[a+i]), int'(gold[a+i]));
   endtask

   task automatic check_rx(string req, int idx, int a, int n);
      for (int i = 0; i < n; i++)
         chk(req, rx[idx+i] === gold[a+i], int'(rx[idx+i]), int'(gold[a+i]));
   endtask

   task automatic t_reset();
      #1;
      chk("R9 reset cmd", mem_cmd == 3'd0, int'(mem_cmd), 0);
      chk("R9 reset strobes", {wr_done, rd_done, rd_valid} == 3'b000,
          int'({wr_done, rd_done, rd_valid}), 0);
   endtask

   task automatic t_write_burst();
      int lat;
      load_wr(16);
      do_write(4, 'h100, lat);
      chk("R3 first word latency", lat == 4, lat, 4);
      check_mem("R4 write burst data", 16, 4);
   endtask

   task automatic t_idle_and_single();
      int w0 = wdone_cnt, o0 = open_cnt, lat;
      repeat (20) @(negedge clk);
      #1;
      chk("R2 no request no activity", (wdone_cnt == w0) && (open_cnt == o0),
          wdone_cnt - w0, 0);
      do_write(1, 'h200, lat);   // continues at 20 without a new load (R1)
      repeat (10) @(negedge clk);
      #1;
      chk("R2 single word", wdone_cnt - w0 == 1, wdone_cnt - w0, 1);
      check_mem("R1 auto increment", 20, 1);
   endtask

   task automatic t_row_cross_write();
      int o0 = open_cnt, c0 = close_cnt, lat;
      load_wr(29);                // row 3 column 5
      do_write(6, 'h300, lat);
      repeat (6) @(negedge clk);
      #1;
      chk("R6 row reopened", open_cnt - o0 == 2, open_cnt - o0, 2);
      chk("R6 row closed", close_cnt - c0 == 2, close_cnt - c0, 2);
      check_mem("R6 data across row", 29, 6);
   endtask

   task automatic t_read_back();
      int idx;
      load_rd(16);
      do_read(5, idx);
      check_rx("R5 read data", idx, 16, 5);
      load_rd(29);
      do_read(6, idx);
      check_rx("R6 read across row", idx, 29, 6);
      chk("R5 valid lag", lag_err == 0, lag_err, 0);
   endtask

   task automatic t_concurrent();
      int s0 = switches, idx, lat;
      load_wr(48);
      load_rd(16);
      fork
         do_write(4, 'h400, lat);
         do_read(4, idx);
      join
      repeat (4) @(negedge clk);
      #1;
      chk("R7 no shared cycle", both_cnt == 0, both_cnt, 0);
      chk("R7 one switch each way", switches - s0 == 2, switches - s0, 2);
      check_mem("R7 write data", 48, 4);
      check_rx("R7 read data", idx, 16, 4);
   endtask

   task automatic t_refresh();
      int r0;
      repeat (50) @(negedge clk);
      #1;
      r0 = rfsh_cnt;
      repeat (1000) @(negedge clk);
      #1;
      chk("R8 refresh period", rfsh_cnt - r0 == 2, rfsh_cnt - r0, 2);
      chk("R8 refresh never in open row", rfsh_open_err == 0, rfsh_open_err, 0);
   endtask

   initial begin
      repeat (8) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_write_burst();
      t_idle_and_single();
      t_row_cross_write();
      t_read_back();
      t_concurrent();
      t_refresh();
      summary();
   end
endmodule